// File: doc/BRIEF.md
# Branch Direction Predictor with Static Miss Rule

This block guesses, for a fetched branch, whether it will be taken and where it goes. It keeps a small direct-mapped table of branches. Each row holds a valid bit, an address tag, a stored target and a two-bit saturating confidence counter. Each cycle the front end presents the fetch address and the target that its decoder worked out. If the table holds a row for that branch, the counter's upper bit gives the direction and the stored target is returned. If there is no row, a fixed rule applies: a branch that jumps to a lower address is assumed to close a loop and is predicted taken. Any other branch is predicted not taken, and the decoded target is passed through.

When a branch resolves further down the pipe, the resolve port reports its address, its real target and whether it was taken. A row that matches is trained. A taken branch with no row gets a new row. A configuration input `erratum_en` selects a deliberately faulty counter rule. Under that rule a not-taken outcome in the strongest taken state drops the counter to the strongest not-taken state.

The counter is a four-state machine of type `ctr_e`. Its states are `CTR_SNT` (0, strongly not taken), `CTR_WNT` (1, weakly not taken), `CTR_WT` (2, weakly taken) and `CTR_STK` (3, strongly taken). Its transitions are these:
- "strengthen": a taken outcome moves up one state and stays at `CTR_STK`.
- "weaken": a not-taken outcome moves down one state and stays at `CTR_SNT`.
- "collapse": in erratum mode only, a not-taken outcome moves `CTR_STK` straight to `CTR_SNT`.

A new row enters the weak state chosen by `INIT_TAKEN`.

Top module: `bp_predictor`

## Requirements
- R1: A lookup hits (`lk_hit`=1) only when the row at its index is valid and its tag matches. On a hit, `lk_taken` is 1 exactly when the counter is 2 or 3, with the encoding 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken, 3 = strongly taken. On a hit, `lk_target` is the stored target.
- R2: On a miss, a branch whose decoded target is lower than its PC (unsigned compare) is predicted taken, and `lk_target` equals the decoded target.
- R3: On a miss, a branch whose decoded target is greater than or equal to its PC is predicted not taken, and `lk_target` equals the decoded target.
- R4: A taken resolve that misses writes a row that is valid and carries the tag, the target and a weak counter state. That state is 2 when `INIT_TAKEN`=1 and 1 otherwise.
- R5: With `erratum_en`=0, a resolve that hits moves the counter up by one on a taken outcome and down by one on a not-taken outcome, and the counter stays within 0 to 3.
- R6: With `erratum_en`=1, a not-taken resolve that hits a row in state 3 sets the counter to 0. Every other transition is the same as in R5.
- R7: The index is PC bits [ALIGN+IDX_W-1:ALIGN] and the tag is the PC bits above them. A PC with the same index and a different tag misses, and a taken resolve for it replaces the row.
- R8: A not-taken resolve that misses changes no row.
- R9: A taken resolve that hits replaces the stored target. A not-taken resolve that hits keeps the stored target.
- R10: A synchronous reset clears every valid bit, so every lookup after reset follows R2 and R3.
- R11: A lookup in the same cycle as a resolve to the same index sees the table contents from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| erratum_en | input | 1 | Selects the faulty strong-taken drop rule |
| lk_pc | input | PC_W | Fetch address of the branch being looked up |
| lk_cand | input | PC_W | Target produced by the decoder for that branch |
| lk_hit | output | 1 | A valid row with a matching tag was found |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | PC_W | Predicted target |
| rs_valid | input | 1 | A resolved branch is presented |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_target | input | PC_W | Actual target of the resolved branch |
| rs_taken | input | 1 | Actual direction of the resolved branch |

## Verification
The assertions check on every cycle the parts of the block that follow from one edge to the next. These are the weak state of a new row, the strengthen and weaken steps, the collapse under the erratum, the rule that a not-taken miss leaves the valid bits alone, and the clearing on reset. Only the bench's scenarios can show the prediction itself. Those scenarios cover the hit and tag-match decode across every index, the backward and forward rule at the boundary where target equals PC, target replacement, aliasing between tags, and the fact that a lookup in the same cycle as a resolve reads the old row. A long trained sequence in both counter modes is compared against an arithmetic model of the counter.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Confidence counter states; the numeric codes are the saturating count.
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_STK = 2'd3
    } ctr_e;

endpackage

// File: rtl/bp_counter_fsm.sv
// Next-state logic of one confidence counter.
module bp_counter_fsm
    import bp_pkg::*;
(
    input  ctr_e cur,
    input  logic taken,
    input  logic erratum_en,
    output ctr_e nxt
);

    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_STK : CTR_WNT;
            CTR_STK: begin
                if (taken)           nxt = CTR_STK;
                else if (erratum_en) nxt = CTR_SNT;   // collapse
                else                 nxt = CTR_WT;    // weaken
            end
        endcase
    end

endmodule

// File: rtl/bp_static_dir.sv
// Direction rule used when the table holds no row for a branch.
module bp_static_dir #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] cand,
    output logic            backward
);

    assign backward = (cand < pc);

endmodule

// File: rtl/bp_table.sv
// Direct-mapped row storage, one write port, all rows visible.
module bp_table #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int TAG_W   = 11,
    parameter int PC_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [PC_W-1:0]             wr_tgt,
    input  logic [1:0]                  wr_ctr,
    output logic [ENTRIES-1:0]          valid_vec,
    output logic [ENTRIES-1:0][TAG_W-1:0] tag_arr,
    output logic [ENTRIES-1:0][PC_W-1:0]  tgt_arr,
    output logic [ENTRIES-1:0][1:0]       ctr_arr
);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_row
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(gi));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_vec[gi] <= 1'b0;
                tag_arr[gi]   <= '0;
                tgt_arr[gi]   <= '0;
                ctr_arr[gi]   <= 2'd0;
            end else if (sel) begin
                valid_vec[gi] <= 1'b1;
                tag_arr[gi]   <= wr_tag;
                tgt_arr[gi]   <= wr_tgt;
                ctr_arr[gi]   <= wr_ctr;
            end
        end
    end

    // R10: reset leaves no valid row behind
    p_reset_clear_r10: assert property (@(posedge clk) rst |=> (valid_vec == '0));

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
    import bp_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int IDX_W      = 3,
    parameter int ALIGN      = 2,
    parameter bit INIT_TAKEN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            erratum_en,
    input  logic [PC_W-1:0] lk_pc,
    input  logic [PC_W-1:0] lk_cand,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_taken
);

    localparam int   ENTRIES = 1 << IDX_W;
    localparam int   TAG_W   = PC_W - IDX_W - ALIGN;
    localparam ctr_e INIT_ST = INIT_TAKEN ? CTR_WT : CTR_WNT;

    logic [ENTRIES-1:0]             valid_vec;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_arr;
    logic [ENTRIES-1:0][PC_W-1:0]   tgt_arr;
    logic [ENTRIES-1:0][1:0]        ctr_arr;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;
    logic             lk_match, rs_match, backward;
    ctr_e             rs_cur, rs_nxt;

    logic             wr_en;
    logic [PC_W-1:0]  wr_tgt;
    ctr_e             wr_ctr;

    assign lk_idx = lk_pc[ALIGN +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign rs_idx = rs_pc[ALIGN +: IDX_W];
    assign rs_tag = rs_pc[PC_W-1 -: TAG_W];

    assign lk_match = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
    assign rs_match = valid_vec[rs_idx] && (tag_arr[rs_idx] == rs_tag);
    assign rs_cur   = ctr_e'(ctr_arr[rs_idx]);

    bp_table #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .PC_W    (PC_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (rs_idx),
        .wr_tag    (rs_tag),
        .wr_tgt    (wr_tgt),
        .wr_ctr    (wr_ctr),
        .valid_vec (valid_vec),
        .tag_arr   (tag_arr),
        .tgt_arr   (tgt_arr),
        .ctr_arr   (ctr_arr)
    );

    bp_counter_fsm u_fsm (
        .cur        (rs_cur),
        .taken      (rs_taken),
        .erratum_en (erratum_en),
        .nxt        (rs_nxt)
    );

    bp_static_dir #(.PC_W(PC_W)) u_static (
        .pc       (lk_pc),
        .cand     (lk_cand),
        .backward (backward)
    );

    // Training: update a matching row, allocate only for taken misses.
    always_comb begin
        wr_en  = 1'b0;
        wr_tgt = rs_target;
        wr_ctr = INIT_ST;
        if (rs_valid) begin
            if (rs_match) begin
                wr_en  = 1'b1;
                wr_ctr = rs_nxt;
                wr_tgt = rs_taken ? rs_target : tgt_arr[rs_idx];
            end else if (rs_taken) begin
                wr_en  = 1'b1;
                wr_ctr = INIT_ST;
            end
        end
    end

    // Prediction outputs.
    always_comb begin
        lk_hit = lk_match;
        if (lk_match) begin
            lk_taken  = ctr_arr[lk_idx][1];
            lk_target = tgt_arr[lk_idx];
        end else begin
            lk_taken  = backward;
            lk_target = lk_cand;
        end
    end

    // R4: a fresh row starts weak
    p_alloc_weak_r4: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_match && rs_taken) |=>
        (valid_vec[$past(rs_idx)] && ctr_arr[$past(rs_idx)] == 2'(INIT_ST)));

    // R5: normal mode drops one step from the strongest taken state
    p_normal_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_match && !rs_taken && !erratum_en && rs_cur == CTR_STK) |=>
        (ctr_arr[$past(rs_idx)] == 2'd2));

    // R5: taken outcome strengthens a non-saturated counter by one
    p_strengthen_r5: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_match && rs_taken && rs_cur != CTR_STK) |=>
        (ctr_arr[$past(rs_idx)] == $past(ctr_arr[rs_idx]) + 2'd1));

    // R6: erratum mode collapses strongly taken to strongly not taken
    p_collapse_r6: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_match && !rs_taken && erratum_en && rs_cur == CTR_STK) |=>
        (ctr_arr[$past(rs_idx)] == 2'd0));

    // R8: a not-taken miss never creates or removes a row
    p_nt_miss_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_match && !rs_taken) |=> $stable(valid_vec));

endmodule

// File: tb/bp_predictor_tb.sv
module bp_predictor_tb;

    localparam int PC_W = 16, IDX_W = 3, ALIGN = 2, N = 8;

    logic            clk = 1'b0, rst = 1'b1, erratum_en = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, lk_cand = '0, rs_pc = '0, rs_target = '0;
    logic            rs_valid = 1'b0, rs_taken = 1'b0;
    logic            lk_hit, lk_taken;
    logic [PC_W-1:0] lk_target;

    int errs = 0, checks = 0;
    bit done = 0;
    int m_v[N], m_tag[N], m_tgt[N], m_ctr[N];

    always #10 clk = ~clk;   // 50 MHz

    bp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN), .INIT_TAKEN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .erratum_en(erratum_en),
        .lk_pc(lk_pc), .lk_cand(lk_cand), .lk_hit(lk_hit), .lk_taken(lk_taken),
        .lk_target(lk_target), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_target(rs_target), .rs_taken(rs_taken)
    );

    function automatic int idx_of(logic [PC_W-1:0] pc); return int'(pc[4:2]); endfunction
    function automatic int tag_of(logic [PC_W-1:0] pc); return int'(pc[15:5]); endfunction
    function automatic logic [PC_W-1:0] mk_pc(int tag, int idx);
        return {11'(tag), 3'(idx), 2'b00};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_ctr[i] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_clear();
    endtask

    // Drive a lookup and compare against the model (before the next edge).
    task automatic look(logic [PC_W-1:0] pc, logic [PC_W-1:0] cand, string req);
        int i; bit hit; int et, eg;
        @(negedge clk); lk_pc = pc; lk_cand = cand; #1;
        i   = idx_of(pc);
        hit = (m_v[i] != 0) && (m_tag[i] == tag_of(pc));
        et  = hit ? int'(m_ctr[i] >= 2) : int'(cand < pc);
        eg  = hit ? m_tgt[i] : int'(cand);
        check({req, " hit"}, int'(lk_hit), int'(hit));
        check({req, " dir"}, int'(lk_taken), et);
        check({req, " tgt"}, int'(lk_target), eg);
    endtask

    task automatic model_resolve(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt, bit tkn);
        int i; bit hit;
        i   = idx_of(pc);
        hit = (m_v[i] != 0) && (m_tag[i] == tag_of(pc));
        if (hit) begin
            if (tkn) begin m_ctr[i] = (m_ctr[i] == 3) ? 3 : m_ctr[i] + 1; m_tgt[i] = int'(tgt); end
            else if (m_ctr[i] == 3 && erratum_en) m_ctr[i] = 0;
            else m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
        end else if (tkn) begin
            m_v[i] = 1; m_tag[i] = tag_of(pc); m_tgt[i] = int'(tgt); m_ctr[i] = 2;
        end
    endtask

    task automatic resolve(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt, bit tkn);
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = pc; rs_target = tgt; rs_taken = tkn;
        model_resolve(pc, tgt, tkn);
        @(negedge clk); rs_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic [PC_W-1:0] p;
        do_reset();
        // R10: after reset every lookup misses; R2/R3 static rule on every index
        for (int i = 0; i < N; i++) begin
            p = mk_pc(5 + i, i);
            look(p, p - 16'd8, "R10 R2 backward");
            look(p, p + 16'd8, "R10 R3 forward");
            look(p, p, "R3 equal");
        end
        // R4: allocate each index on a taken miss, check weak-taken hit
        for (int i = 0; i < N; i++) begin
            p = mk_pc(5 + i, i);
            resolve(p, p + 16'd64, 1'b1);
            look(p, p - 16'd4, "R4 R1 alloc");
        end
        // R5 targeted: saturate, one not-taken stays taken
        p = mk_pc(5 + 5, 5);
        erratum_en = 1'b0;
        resolve(p, p + 16'd64, 1'b1); resolve(p, p + 16'd64, 1'b1); resolve(p, p + 16'd64, 1'b1);
        resolve(p, p + 16'd64, 1'b0);
        look(p, p, "R5 normal drop");
        check("R5 state2 predicts taken", int'(lk_taken), 1);
        // R6 targeted: with erratum, collapse to not taken
        resolve(p, p + 16'd64, 1'b1);
        erratum_en = 1'b1;
        resolve(p, p + 16'd64, 1'b0);
        look(p, p, "R6 collapse");
        check("R6 state0 predicts not taken", int'(lk_taken), 0);
        resolve(p, p + 16'd64, 1'b1);
        look(p, p, "R6 after collapse one taken");
        erratum_en = 1'b0;
        // R9: target replacement on taken hit, kept on not-taken hit
        p = mk_pc(5 + 2, 2);
        resolve(p, 16'h1230, 1'b1);
        look(p, p, "R9 new target");
        resolve(p, 16'h4440, 1'b0);
        look(p, p, "R9 kept target");
        // R7: alias with another tag misses, taken alias replaces row
        p = mk_pc(300, 3);
        look(p, p - 16'd4, "R7 alias miss");
        resolve(p, 16'h0abc, 1'b1);
        look(p, p, "R7 alias hit");
        look(mk_pc(8, 3), mk_pc(8, 3) + 16'd4, "R7 evicted");
        // R8: not-taken miss does nothing
        p = mk_pc(400, 4);
        resolve(p, p - 16'd16, 1'b0);
        look(p, p - 16'd16, "R8 no alloc");
        look(mk_pc(9, 4), mk_pc(9, 4), "R8 neighbour kept");
        // R11: same-cycle lookup and resolve to a fresh index sees old row
        do_reset();
        p = mk_pc(77, 6);
        @(negedge clk);
        lk_pc = p; lk_cand = p + 16'd20;
        rs_valid = 1'b1; rs_pc = p; rs_target = 16'h0f00; rs_taken = 1'b1;
        #1;
        check("R11 same-cycle hit old", int'(lk_hit), 0);
        check("R11 same-cycle tgt old", int'(lk_target), int'(p + 16'd20));
        model_resolve(p, 16'h0f00, 1'b1);
        @(negedge clk); rs_valid = 1'b0;
        look(p, p, "R11 after write");
        // R5/R6 sweep: pseudo-random training in both modes against the model
        lf = 16'hace1;
        for (int m = 0; m < 2; m++) begin
            do_reset();
            erratum_en = (m == 1);
            for (int k = 0; k < 600; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                p = mk_pc(20 + int'(lf[7]), int'(lf[2:0]));
                resolve(p, {lf[15:8], 8'h40}, lf[3] | lf[9]);
                look(p, p ^ 16'h0020, m == 1 ? "R6 sweep" : "R5 sweep");
            end
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule